// File: doc/BRIEF.md
# Dual-Channel High/Low Count PWM Generator

This block drives two independent pulse-width-modulated outputs. Each channel is programmed with a high duration and a low duration, both counted in prescaled ticks. The output is high for the high duration, then low for the low duration, and then repeats. A channel picks one of four tick-enable source inputs. A 7-bit divider thins that source, and a gate can hold the counter still. Each channel also has an output enable. Clearing the enable drops the output at once, without waiting for the period to end.

Software reaches the block through a plain synchronous word bus with three registers. Word 0 holds the counts for channel A and word 1 holds the counts for channel B. Word 2 is a control word that both channels share. New counts and a new divider written while a channel runs take effect only at the next period boundary, so no phase is ever cut short. The tick sources are single-cycle enables in the system clock domain.

Top module: `twin_pwm`

## Requirements
- R1: Word index 0 (byte 0x0) holds channel A's counts and word 1 (byte 0x4) holds channel B's counts, with the high count in bits 31:16 and the low count in bits 15:0; both read back as written. Word 2 (byte 0x8) is the control word and reads back masked with 0x00FFFFF3. Word 3 reads zero and ignores writes.
- R2: After reset every register reads zero and both outputs are low.
- R3: With a high count H > 0 and a low count L > 0, a running channel with divider value D (bits 14:8 for A, 22:16 for B) outputs H×(D+1) cycles high and then L×(D+1) cycles low, repeating, when its source ticks every cycle.
- R4: Setting a channel's enable bit (bit 0 for A, bit 1 for B) starts the channel in the high phase, with a cleared count and a cleared prescaler. The first high cycle is the second cycle after the edge at which the bus write is taken.
- R5: Clearing a channel's enable bit forces its output low in the first cycle after the edge that takes the write, even in the middle of a high phase.
- R6: A high count of zero gives a constant low output, also when the low count is zero.
- R7: A low count of zero with a nonzero high count gives a constant high output.
- R8: While a channel's gate bit (bit 15 for A, bit 23 for B) is clear, its counter receives no ticks and its output holds its level. Setting the gate resumes counting from where it stopped.
- R9: The source select (bits 5:4 for A, bits 7:6 for B) picks which bit of `src_tick` advances the channel; ticks on the other bits have no effect.
- R10: Counts or a divider written while a channel runs take effect at the next period boundary. The period in progress completes with the old values.
- R11: The two channels run concurrently with independent counts, dividers and enables.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, taken on the rising clock edge |
| bus_word | input | 2 | Word index of the register (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_word`, combinational |
| src_tick | input | 4 | Tick enables of the four selectable clock sources |
| pwm_out | output | 2 | Channel outputs, bit 0 is A and bit 1 is B |

## Verification
A register write lands on the edge that samples the strobe. When a channel is idle, the channel latches its counts at the next edge, and its output shows the first high cycle after that edge; the bench therefore counts cycle zero at the second falling edge after the write strobe is raised. Clearing an enable gates the output combinationally from the control register, so the output is low at the first falling edge after the write. Every waveform sample is compared with a closed-form position-in-period formula, and each count change is placed at a known cycle, so the boundary cycle at which the new values take over is known exactly.

// File: rtl/twin_pwm_pkg.sv
package twin_pwm_pkg;
  localparam int NCH       = 2;
  localparam int DW        = 32;
  localparam int WORD_W    = 2;
  localparam int CNT_W     = 16;
  localparam int DIV_W     = 7;
  localparam int SEL_W     = 2;
  localparam int NSRC      = 1 << SEL_W;
  localparam int SEL_BASE  = 4;
  localparam int DIV_BASE  = 8;
  localparam int GATE_BASE = 15;
  localparam int CH_STRIDE = 8;
  localparam int CTRL_WORD = NCH;

  function automatic int en_bit(input int ch);
    return ch;
  endfunction

  function automatic int sel_lsb(input int ch);
    return SEL_BASE + SEL_W * ch;
  endfunction

  function automatic int div_lsb(input int ch);
    return DIV_BASE + CH_STRIDE * ch;
  endfunction

  function automatic int gate_bit(input int ch);
    return GATE_BASE + CH_STRIDE * ch;
  endfunction

  function automatic logic [DW-1:0] ctrl_mask();
    logic [DW-1:0] m;
    m = '0;
    for (int c = 0; c < NCH; c++) begin
      m[en_bit(c)]   = 1'b1;
      m[gate_bit(c)] = 1'b1;
      for (int b = 0; b < SEL_W; b++) m[sel_lsb(c) + b] = 1'b1;
      for (int b = 0; b < DIV_W; b++) m[div_lsb(c) + b] = 1'b1;
    end
    return m;
  endfunction

  // True when count c is on the last tick of a phase of length n (n > 0).
  function automatic logic is_last(input logic [CNT_W-1:0] c,
                                   input logic [CNT_W-1:0] n);
    return (n != '0) && (c == n - 1'b1);
  endfunction
endpackage

// File: rtl/twin_pwm_regs.sv
module twin_pwm_regs
  import twin_pwm_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr,
  input  logic [WORD_W-1:0]      word,
  input  logic [DW-1:0]          wdata,
  output logic [DW-1:0]          rdata,
  output logic [NCH-1:0][DW-1:0] cnt_q,
  output logic [DW-1:0]          ctrl_q
);
  localparam logic [DW-1:0] MASK = ctrl_mask();

  for (genvar c = 0; c < NCH; c++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rst_n)                         cnt_q[c] <= '0;
      else if (wr && (int'(word) == c))   cnt_q[c] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                ctrl_q <= '0;
    else if (wr && (int'(word) == CTRL_WORD))  ctrl_q <= wdata & MASK;
  end

  always_comb begin
    rdata = '0;
    if (int'(word) < NCH)             rdata = cnt_q[word[0]];
    else if (int'(word) == CTRL_WORD) rdata = ctrl_q;
  end
endmodule

// File: rtl/twin_pwm_chan.sv
module twin_pwm_chan
  import twin_pwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             gate,
  input  logic [SEL_W-1:0] sel,
  input  logic [DIV_W-1:0] div,
  input  logic [CNT_W-1:0] hi,
  input  logic [CNT_W-1:0] lo,
  input  logic [NSRC-1:0]  src_tick,
  output logic             out,
  output logic             step_o,
  output logic             bound_o,
  output logic             run_o
);
  logic             run_q, ph_hi_q;
  logic [CNT_W-1:0] cnt_q, act_hi, act_lo;
  logic [DIV_W-1:0] pre_q, act_div;
  logic             tick, pre_wrap, step, hi_done, lo_done, bound;

  assign tick     = src_tick[sel];
  assign pre_wrap = (pre_q == act_div);
  assign step     = run_q && en && gate && tick && pre_wrap;
  assign hi_done  = ph_hi_q && is_last(cnt_q, act_hi);
  assign lo_done  = !ph_hi_q && ((act_lo == '0) || is_last(cnt_q, act_lo));
  assign bound    = step && ((hi_done && (act_lo == '0)) || lo_done);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      run_q   <= 1'b0;
      ph_hi_q <= 1'b0;
      cnt_q   <= '0;
      pre_q   <= '0;
      act_hi  <= '0;
      act_lo  <= '0;
      act_div <= '0;
    end else if (!run_q) begin
      run_q   <= 1'b1;
      ph_hi_q <= (hi != '0);
      cnt_q   <= '0;
      pre_q   <= '0;
      act_hi  <= hi;
      act_lo  <= lo;
      act_div <= div;
    end else begin
      if (gate && tick) pre_q <= pre_wrap ? '0 : pre_q + 1'b1;
      if (bound) begin
        act_hi  <= hi;
        act_lo  <= lo;
        act_div <= div;
        ph_hi_q <= (hi != '0);
        cnt_q   <= '0;
      end else if (step && hi_done) begin
        ph_hi_q <= 1'b0;
        cnt_q   <= '0;
      end else if (step) begin
        cnt_q   <= cnt_q + 1'b1;
      end
    end
  end

  assign out     = run_q && en && ph_hi_q;
  assign step_o  = step;
  assign bound_o = bound;
  assign run_o   = run_q;
endmodule

// File: rtl/twin_pwm.sv
module twin_pwm
  import twin_pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [WORD_W-1:0] bus_word,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [NSRC-1:0]   src_tick,
  output logic [NCH-1:0]    pwm_out
);
  logic [NCH-1:0][DW-1:0] cnt_w;
  logic [DW-1:0]          ctrl_w;
  logic [NCH-1:0]         step_w, bound_w, run_w;

  twin_pwm_regs u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (bus_wr),
    .word   (bus_word),
    .wdata  (bus_wdata),
    .rdata  (bus_rdata),
    .cnt_q  (cnt_w),
    .ctrl_q (ctrl_w)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    twin_pwm_chan u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (ctrl_w[en_bit(c)]),
      .gate     (ctrl_w[gate_bit(c)]),
      .sel      (ctrl_w[sel_lsb(c) +: SEL_W]),
      .div      (ctrl_w[div_lsb(c) +: DIV_W]),
      .hi       (cnt_w[c][DW-1 -: CNT_W]),
      .lo       (cnt_w[c][CNT_W-1:0]),
      .src_tick (src_tick),
      .out      (pwm_out[c]),
      .step_o   (step_w[c]),
      .bound_o  (bound_w[c]),
      .run_o    (run_w[c])
    );
  end
endmodule

// File: rtl/twin_pwm_checks.sv
module twin_pwm_checks
  import twin_pwm_pkg::*;
(
  input logic                   clk,
  input logic                   rst_n,
  input logic [DW-1:0]          ctrl,
  input logic [NCH-1:0][DW-1:0] cnt,
  input logic [NSRC-1:0]        src_tick,
  input logic [NCH-1:0]         pwm_out,
  input logic [NCH-1:0]         step,
  input logic [NCH-1:0]         bound,
  input logic [NCH-1:0]         run
);
  for (genvar c = 0; c < NCH; c++) begin : g_chk
    // R5: a cleared enable keeps the output low
    p_stop_now_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl[en_bit(c)] |-> !pwm_out[c]);

    // R8: no phase step while the gate is off
    p_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl[gate_bit(c)] |-> !step[c]);

    // R9: a step needs a tick on the selected source
    p_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
      step[c] |-> src_tick[ctrl[sel_lsb(c) +: SEL_W]]);

    // R3: the output level only changes on a step
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (run[c] && !step[c]) |=> (!ctrl[en_bit(c)] || $stable(pwm_out[c])));

    // R4: a fresh start is high unless the high count is zero
    p_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(run[c]) && ctrl[en_bit(c)]) |->
        (pwm_out[c] == ($past(cnt[c][DW-1 -: CNT_W]) != '0)));

    // R10: a period boundary is always a step
    p_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
      bound[c] |-> step[c]);
  end
endmodule

bind twin_pwm twin_pwm_checks u_checks (
  .clk      (clk),
  .rst_n    (rst_n),
  .ctrl     (ctrl_w),
  .cnt      (cnt_w),
  .src_tick (src_tick),
  .pwm_out  (pwm_out),
  .step     (step_w),
  .bound    (bound_w),
  .run      (run_w)
);

// File: tb/twin_pwm_test.sv
module twin_pwm_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_word = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  src_tick = 4'b0001;
  logic [1:0]  pwm_out;
  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  twin_pwm uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_word(bus_word),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_tick(src_tick),
    .pwm_out(pwm_out)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic wr_reg(input int w, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_word = 2'(w); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input int w, output logic [31:0] d);
    @(negedge clk);
    bus_word = 2'(w);
    #1 d = bus_rdata;
  endtask

  function automatic logic [31:0] ctrl_word(bit ea, bit eb, bit ga, bit gb,
      int sa, int sb, int da, int db);
    logic [31:0] v;
    v = '0;
    v[0] = ea; v[1] = eb;
    v[5:4] = 2'(sa); v[7:6] = 2'(sb);
    v[14:8] = 7'(da); v[15] = ga;
    v[22:16] = 7'(db); v[23] = gb;
    return v;
  endfunction

  function automatic bit exp_out(int k, int hi, int lo, int d);
    if (hi == 0) return 1'b0;
    if (lo == 0) return 1'b1;
    return (k % ((hi + lo) * (d + 1))) < hi * (d + 1);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] rv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2: reset state
    for (int w = 0; w < 3; w++) begin
      rd_reg(w, rv);
      check(rv == 0, "R2", "reset register", rv, 0);
    end
    check(pwm_out == 2'b00, "R2", "reset outputs", pwm_out, 0);

    // R1: register map and read-back
    wr_reg(0, 32'hDEADBEEF);
    wr_reg(1, 32'h12345678);
    wr_reg(2, 32'hFFFFFFFC);
    wr_reg(3, 32'hFFFFFFFF);
    rd_reg(0, rv); check(rv == 32'hDEADBEEF, "R1", "count A", rv, 32'hDEADBEEF);
    rd_reg(1, rv); check(rv == 32'h12345678, "R1", "count B", rv, 32'h12345678);
    rd_reg(2, rv); check(rv == 32'h00FFFFF0, "R1", "control mask", rv, 32'h00FFFFF0);
    rd_reg(3, rv); check(rv == 0, "R1", "word 3", rv, 0);
    wr_reg(2, 0);

    // R3 R6 R7 R11: sweep, channel B runs mirrored settings at the same time
    for (int hi = 0; hi < 4; hi++)
      for (int lo = 0; lo < 4; lo++)
        for (int d = 0; d < 3; d++) begin
          bit okA = 1'b1, okB = 1'b1;
          int badk = -1;
          wr_reg(0, {16'(hi), 16'(lo)});
          wr_reg(1, {16'(lo), 16'(hi)});
          wr_reg(2, ctrl_word(1, 1, 1, 1, 0, 0, d, 2 - d));
          for (int k = 0; k < 50; k++) begin
            @(negedge clk);
            if (pwm_out[0] != exp_out(k, hi, lo, d)) begin okA = 0; badk = k; end
            if (pwm_out[1] != exp_out(k, lo, hi, 2 - d)) begin okB = 0; badk = k; end
          end
          if (hi == 0)      check(okA, "R6", "chan A constant low", badk, -1);
          else if (lo == 0) check(okA, "R7", "chan A constant high", badk, -1);
          else              check(okA, "R3", "chan A waveform", badk, -1);
          check(okB, "R11", "chan B concurrent waveform", badk, -1);
          wr_reg(2, 0);
        end

    // R5: stop in the middle of a high phase
    wr_reg(0, {16'd10, 16'd5});
    wr_reg(2, ctrl_word(1, 0, 1, 0, 0, 0, 0, 0));
    repeat (3) @(negedge clk);
    check(pwm_out[0] == 1'b1, "R5", "high before stop", pwm_out[0], 1);
    wr_reg(2, ctrl_word(0, 0, 1, 0, 0, 0, 0, 0));
    check(pwm_out[0] == 1'b0, "R5", "low right after stop", pwm_out[0], 0);

    // R4: restart after stopping in the low phase begins fresh
    begin
      bit ok = 1'b1;
      wr_reg(0, {16'd3, 16'd3});
      wr_reg(2, ctrl_word(1, 0, 1, 0, 0, 0, 0, 0));
      repeat (5) @(negedge clk);
      wr_reg(2, 0);
      wr_reg(2, ctrl_word(1, 0, 1, 0, 0, 0, 0, 0));
      for (int k = 0; k < 12; k++) begin
        @(negedge clk);
        if (pwm_out[0] != exp_out(k, 3, 3, 0)) ok = 0;
      end
      check(ok, "R4", "fresh restart pattern", ok, 1);
      wr_reg(2, 0);
    end

    // R8: gate off freezes, gate on resumes
    begin
      bit ok = 1'b1;
      wr_reg(0, {16'd2, 16'd2});
      wr_reg(2, ctrl_word(1, 0, 0, 0, 0, 0, 0, 0));
      for (int k = 0; k < 10; k++) begin
        @(negedge clk);
        if (pwm_out[0] != 1'b1) ok = 0;
      end
      check(ok, "R8", "frozen while gated", ok, 1);
      ok = 1'b1;
      wr_reg(2, ctrl_word(1, 0, 1, 0, 0, 0, 0, 0));
      for (int j = 0; j < 8; j++) begin
        if (j > 0) @(negedge clk);
        if (pwm_out[0] != exp_out(j, 2, 2, 0)) ok = 0;
      end
      check(ok, "R8", "resumes after gate on", ok, 1);
      wr_reg(2, 0);
    end

    // R9: source select
    begin
      bit ok = 1'b1;
      src_tick = 4'b0100;
      wr_reg(0, {16'd1, 16'd1});
      wr_reg(2, ctrl_word(1, 0, 1, 0, 1, 0, 0, 0));
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        if (pwm_out[0] != 1'b1) ok = 0;
      end
      check(ok, "R9", "idle source gives no steps", ok, 1);
      wr_reg(2, 0);
      ok = 1'b1;
      wr_reg(2, ctrl_word(1, 0, 1, 0, 2, 0, 0, 0));
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        if (pwm_out[0] != exp_out(k, 1, 1, 0)) ok = 0;
      end
      check(ok, "R9", "selected source drives steps", ok, 1);
      wr_reg(2, 0);
      src_tick = 4'b0001;
    end

    // R10: new counts written mid-period take effect at the boundary
    begin
      bit ok = 1'b1;
      int badk = -1;
      wr_reg(0, {16'd3, 16'd2});
      wr_reg(2, ctrl_word(1, 0, 1, 0, 0, 0, 0, 0));
      for (int k = 0; k < 15; k++) begin
        bit e;
        @(negedge clk);
        e = (k < 5) ? exp_out(k, 3, 2, 0) : exp_out(k - 5, 1, 1, 0);
        if (pwm_out[0] != e) begin ok = 0; badk = k; end
        if (k == 1) begin bus_wr = 1'b1; bus_word = 2'd0; bus_wdata = {16'd1, 16'd1}; end
        if (k == 2) bus_wr = 1'b0;
      end
      check(ok, "R10", "shadowed count update", badk, -1);
      wr_reg(2, 0);
    end

    summary();
    $finish;
  end
endmodule